// File: doc/BRIEF.md
# Open-Row Strobe Sequencer for Multiplexed-Address DRAM

This block sits between a simple host request port and an asynchronous DRAM with a shared row/column address bus. It turns each host read or write into the strobe sequence the memory expects: row address and row strobe, then column address and column strobe, with write-enable and output-enable set for the access type. Writes are always early writes, so the memory's data pins stay off the bus for the whole write. Reads capture the data bus once both the column-strobe access window and the row-strobe access window have run out. The captured word comes back with a one-cycle response pulse.

After an access the row stays open. A later request to the same row issues only a column cycle. The column address is placed on the bus while the column strobe is still high, because the memory passes it through until the strobe falls. A request to another row, an external refresh request, or running out of row-strobe time closes the row first and then waits out the row precharge. Every delay is a parameter counted in clock cycles. The maximum row-strobe-low time is enforced by only starting a column access when the worst-case access still fits in the remaining budget.

Top module: `pagedram_ctrl`

## Requirements
- R1: The upper AW bits of the host address (`req_addr_i[2*AW-1:AW]`) are on `dram_addr_o` and unchanged for at least one cycle before `dram_ras_no` falls. The lower AW bits (`req_addr_i[AW-1:0]`) are on `dram_addr_o` when `dram_cas_no` falls.
- R2: A request whose row equals the open row is served with a column strobe cycle only. `dram_ras_no` stays low and does not fall again for it. `dram_cas_no` is low only while `dram_ras_no` is low.
- R3: A request to a different row first raises `dram_ras_no`. The row strobe then stays high for at least T_RP cycles before it falls again.
- R4: The column address is driven while `dram_cas_no` is high and is held at least T_ASC cycles before `dram_cas_no` falls.
- R5: On a write, `dram_we_no` is already low in the cycle before `dram_cas_no` falls. `dram_oe_no` stays high while `dram_we_no` is low. `dram_dq_oe_o` is 1 and `dram_dq_o` carries the write data when the column strobe falls.
- R6: On a read, `dram_oe_no` falls together with `dram_cas_no`. `dram_dq_i` is sampled only after at least T_CAC cycles of column strobe low and at least T_RAC cycles of row strobe low. The sampled value appears on `rsp_rdata_o` with `rsp_valid_o` high for exactly one cycle.
- R7: `dram_ras_no` is never low for more than T_RASP consecutive cycles. When the remaining budget cannot cover another access, the open row is closed.
- R8: The column strobe is high for at least T_CP cycles and low for at least T_CAS cycles. Two falls of the column strobe are at least T_PC cycles apart.
- R9: While `refresh_i` is 1, an open row is closed and `req_ready_o` is 0.
- R10: After reset all four strobes are high, `dram_dq_oe_o` is 0, `rsp_valid_o` is 0 and `req_ready_o` is 1.
- R11: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 in the cycle after a request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_i | input | 1 | External request to close the open row |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 2*AW | Word address, row in the upper half |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | DW | Read data |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_addr_o | output | AW | Multiplexed row/column address |
| dram_dq_o | output | DW | Data toward memory |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | DW | Data from memory |

## Verification
The bench models the memory behaviourally. That model returns the inverted word whenever it is sampled before the column-strobe or row-strobe access window has passed, so a capture taken too early shows up as a data mismatch. The bench runs a write followed by a read of the same row, which separates a true page hit from a needless reopen. Row-changing reads separate the close-and-precharge path from a hit. A long same-row burst checks that the row-strobe budget forces a reopen. A refresh request arriving while a row is open, and accesses at the all-zero and all-ones address corners, check the bus split and the close path.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RADR,
    ST_RCD,
    ST_COL,
    ST_CAS,
    ST_CP,
    ST_PRE
  } pdc_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdc_span_cnt.sv
module pdc_span_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pdc_row_track.sv
module pdc_row_track #(
  parameter int AW       = 10,
  parameter int RAS_W    = 8,
  parameter int CAGE_W   = 4,
  parameter int RAS_SAT  = 100,
  parameter int CAGE_SAT = 13,
  parameter int BUDGET   = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              close_i,
  input  logic              cas_fall_i,
  input  logic [AW-1:0]     open_row_i,
  input  logic [AW-1:0]     req_row_i,
  output logic              row_open_o,
  output logic              hit_o,
  output logic              budget_ok_o,
  output logic [RAS_W-1:0]  ras_age_o,
  output logic [CAGE_W-1:0] cas_age_o
);

  logic              open_q;
  logic [AW-1:0]     row_q;
  logic [RAS_W-1:0]  ras_cnt_q;
  logic [CAGE_W-1:0] cas_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      row_q     <= '0;
      ras_cnt_q <= '0;
      cas_cnt_q <= CAGE_W'(CAGE_SAT);
    end else if (open_i) begin
      open_q    <= 1'b1;
      row_q     <= open_row_i;
      ras_cnt_q <= '0;
      cas_cnt_q <= CAGE_W'(CAGE_SAT);
    end else begin
      if (close_i) open_q <= 1'b0;
      if (open_q && ras_cnt_q != RAS_W'(RAS_SAT)) ras_cnt_q <= ras_cnt_q + 1'b1;
      if (cas_fall_i)                             cas_cnt_q <= '0;
      else if (cas_cnt_q != CAGE_W'(CAGE_SAT))    cas_cnt_q <= cas_cnt_q + 1'b1;
    end
  end

  assign row_open_o  = open_q;
  assign hit_o       = open_q && (row_q == req_row_i);
  assign budget_ok_o = (ras_cnt_q <= RAS_W'(BUDGET));
  assign ras_age_o   = ras_cnt_q;
  assign cas_age_o   = cas_cnt_q;

  // R7: the open row never outlives the maximum strobe-low time
  assert_rasp_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> (ras_cnt_q < RAS_W'(RAS_SAT)));

  // R2: an open row is released only after a close request
  assert_row_close_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && !close_i) |=> open_q);

endmodule

// File: rtl/pagedram_ctrl.sv
module pagedram_ctrl import pdc_pkg::*; #(
  parameter int AW     = 10,
  parameter int DW     = 4,
  parameter int T_RCD  = 5,
  parameter int T_ASC  = 1,
  parameter int T_CAS  = 5,
  parameter int T_CAC  = 5,
  parameter int T_RAC  = 20,
  parameter int T_CP   = 3,
  parameter int T_PC   = 13,
  parameter int T_RP   = 15,
  parameter int T_RASP = 25000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            refresh_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_we_i,
  input  logic [2*AW-1:0] req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            rsp_valid_o,
  output logic [DW-1:0]   rsp_rdata_o,
  output logic            dram_ras_no,
  output logic            dram_cas_no,
  output logic            dram_we_no,
  output logic            dram_oe_no,
  output logic [AW-1:0]   dram_addr_o,
  output logic [DW-1:0]   dram_dq_o,
  output logic            dram_dq_oe_o,
  input  logic [DW-1:0]   dram_dq_i
);

  localparam int CAS_HOLD = imax(T_CAS, imax(T_CAC, T_RAC));
  localparam int ACC_MAX  = T_ASC + T_PC + CAS_HOLD + T_CP + 4;
  localparam int BUDGET   = T_RASP - ACC_MAX;
  localparam int RAS_W    = $clog2(T_RASP + 1);
  localparam int CAGE_SAT = imax(T_PC, T_CAC);
  localparam int CAGE_W   = $clog2(CAGE_SAT + 1);
  localparam int T_MAXW   = imax(imax(T_RP, T_RCD), imax(imax(T_ASC, T_CAS), T_CP));
  localparam int TW       = imax($clog2(T_MAXW + 1), 1);

  pdc_state_e        state_q;
  logic              we_q;
  logic [AW-1:0]     col_q;
  logic [DW-1:0]     wdat_q;
  logic              ras_n_q, cas_n_q, we_n_q, oe_n_q, dq_oe_q, rsp_v_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     dq_q, rsp_d_q;

  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_val;
  logic              row_open, hit, budget_ok;
  logic [RAS_W-1:0]  ras_age;
  logic [CAGE_W-1:0] cas_age;

  logic [AW-1:0]     req_row, req_col;
  logic              is_idle, close_c, fire, col_go, cas_done;

  assign req_row = req_addr_i[2*AW-1:AW];
  assign req_col = req_addr_i[AW-1:0];
  assign is_idle = (state_q == ST_IDLE);

  // row must go: refresh, no budget left, or a request to another row
  assign close_c = is_idle && row_open &&
                   (refresh_i || !budget_ok || (req_valid_i && !hit));
  assign req_ready_o = is_idle && !refresh_i && (!row_open || (hit && budget_ok));
  assign fire        = req_valid_i && req_ready_o;

  assign col_go   = tmr_done && (cas_age >= CAGE_W'(T_PC - 1));
  assign cas_done = tmr_done &&
                    (we_q || ((cas_age >= CAGE_W'(T_CAC - 1)) &&
                              (ras_age >= RAS_W'(T_RAC - 1))));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (close_c) begin
          tmr_load = 1'b1; tmr_val = TW'(T_RP - 1);
        end else if (fire && row_open) begin
          tmr_load = 1'b1; tmr_val = TW'(T_ASC - 1);
        end
      end
      ST_RADR: begin tmr_load = 1'b1; tmr_val = TW'(T_RCD - 1); end
      ST_RCD:  if (tmr_done) begin tmr_load = 1'b1; tmr_val = TW'(T_ASC - 1); end
      ST_COL:  if (col_go)   begin tmr_load = 1'b1; tmr_val = TW'(T_CAS - 1); end
      ST_CAS:  if (cas_done) begin tmr_load = 1'b1; tmr_val = TW'(T_CP - 1);  end
      default: ;
    endcase
  end

  pdc_span_cnt #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  pdc_row_track #(
    .AW       (AW),
    .RAS_W    (RAS_W),
    .CAGE_W   (CAGE_W),
    .RAS_SAT  (T_RASP),
    .CAGE_SAT (CAGE_SAT),
    .BUDGET   (BUDGET)
  ) u_row (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_i      (state_q == ST_RADR),
    .close_i     (close_c),
    .cas_fall_i  ((state_q == ST_COL) && col_go),
    .open_row_i  (addr_q),
    .req_row_i   (req_row),
    .row_open_o  (row_open),
    .hit_o       (hit),
    .budget_ok_o (budget_ok),
    .ras_age_o   (ras_age),
    .cas_age_o   (cas_age)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      col_q   <= '0;
      wdat_q  <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      addr_q  <= '0;
      dq_q    <= '0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (close_c) begin
            ras_n_q <= 1'b1;
            state_q <= ST_PRE;
          end else if (fire) begin
            we_q   <= req_we_i;
            col_q  <= req_col;
            wdat_q <= req_wdata_i;
            if (row_open) begin
              // flow-through: column goes out while CAS is still high
              addr_q  <= req_col;
              we_n_q  <= !req_we_i;
              dq_q    <= req_wdata_i;
              dq_oe_q <= req_we_i;
              state_q <= ST_COL;
            end else begin
              addr_q  <= req_row;
              state_q <= ST_RADR;
            end
          end
        end
        ST_RADR: begin
          ras_n_q <= 1'b0;
          state_q <= ST_RCD;
        end
        ST_RCD: begin
          if (tmr_done) begin
            addr_q  <= col_q;
            we_n_q  <= !we_q;
            dq_q    <= wdat_q;
            dq_oe_q <= we_q;
            state_q <= ST_COL;
          end
        end
        ST_COL: begin
          if (col_go) begin
            cas_n_q <= 1'b0;
            oe_n_q  <= we_q;
            state_q <= ST_CAS;
          end
        end
        ST_CAS: begin
          if (cas_done) begin
            if (!we_q) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= dram_dq_i;
            end
            cas_n_q <= 1'b1;
            oe_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            dq_oe_q <= 1'b0;
            state_q <= ST_CP;
          end
        end
        ST_CP:   if (tmr_done) state_q <= ST_IDLE;
        ST_PRE:  if (tmr_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dram_ras_no  = ras_n_q;
  assign dram_cas_no  = cas_n_q;
  assign dram_we_no   = we_n_q;
  assign dram_oe_no   = oe_n_q;
  assign dram_addr_o  = addr_q;
  assign dram_dq_o    = dq_q;
  assign dram_dq_oe_o = dq_oe_q;
  assign rsp_valid_o  = rsp_v_q;
  assign rsp_rdata_o  = rsp_d_q;

  assert_row_addr_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_q) |-> $stable(addr_q));

  assert_cas_under_ras_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_q |-> !ras_n_q);

  assert_precharge_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_q) |=> ras_n_q);

  assert_col_addr_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_q) |-> $stable(addr_q));

  assert_early_we_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_q) && !we_n_q) |-> $stable(we_n_q));

  assert_we_blocks_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |-> oe_n_q);

  assert_rsp_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_v_q |=> !rsp_v_q);

  assert_refresh_close_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_idle && refresh_i && row_open) |=> ras_n_q);

endmodule

// File: tb/pagedram_ctrl_test.sv
`timescale 1ns/1ps
module pagedram_ctrl_test;

  localparam int AW = 10, DW = 4;
  localparam int T_RCD = 5, T_ASC = 1, T_CAS = 5, T_CAC = 5, T_RAC = 20;
  localparam int T_CP = 3, T_PC = 13, T_RP = 15, T_RASP = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh = 1'b0;
  logic req_valid = 1'b0;
  logic req_we = 1'b0;
  logic [2*AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] dq_drv = '0;
  logic req_ready, rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_out;
  logic [AW-1:0] addr;

  always #2 clk = ~clk;

  pagedram_ctrl #(
    .AW(AW), .DW(DW), .T_RCD(T_RCD), .T_ASC(T_ASC), .T_CAS(T_CAS),
    .T_CAC(T_CAC), .T_RAC(T_RAC), .T_CP(T_CP), .T_PC(T_PC),
    .T_RP(T_RP), .T_RASP(T_RASP)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .refresh_i(refresh),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_oe_no(oe_n), .dram_addr_o(addr), .dram_dq_o(dq_out),
    .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_drv)
  );

  int checks = 0;
  int failures = 0;
  int ras_falls = 0;
  logic [AW-1:0] cur_row = '0, cur_col = '0;
  logic [DW-1:0] mem [bit [2*AW-1:0]];
  logic [DW-1:0] shadow [bit [2*AW-1:0]];
  logic [DW-1:0] exp_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] shd(input logic [2*AW-1:0] a);
    return shadow.exists(a) ? shadow[a] : '0;
  endfunction

  function automatic logic [DW-1:0] mrd(input logic [2*AW-1:0] a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  // memory model and per-clock timing monitor
  logic ras_p = 1'b1, cas_p = 1'b1, we_p = 1'b1, rsp_p = 1'b0;
  logic [AW-1:0] addr_p = '0, row_l = '0, col_l = '0;
  int ras_hi = 0, ras_lo = 0, cas_hi = 0, cas_lo = 0, since_fall = 0, addr_age = 0;
  int ras_age = 0, cas_age = 0;
  bit seen_rise = 0, fall_in_row = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ras_p = 1'b1; cas_p = 1'b1; we_p = 1'b1; rsp_p = 1'b0;
      seen_rise = 0; fall_in_row = 0; dq_drv = '0;
    end else begin
      if (addr == addr_p) addr_age++; else addr_age = 1;
      // row strobe
      if (ras_p && !ras_n) begin
        check(addr == cur_row, "R1 row addr", addr, cur_row);
        check(addr_age >= 2, "R1 row setup", addr_age, 2);
        if (seen_rise) check(ras_hi >= T_RP, "R3 precharge", ras_hi, T_RP);
        ras_falls++; ras_lo = 1; row_l = addr; ras_age = 1; fall_in_row = 0;
      end else if (!ras_n) begin
        ras_lo++; ras_age++;
      end
      if (!ras_p && ras_n) begin ras_hi = 1; seen_rise = 1; end
      else if (ras_n) ras_hi++;
      if (!ras_n && ras_lo > T_RASP) check(0, "R7 ras low", ras_lo, T_RASP);
      // column strobe
      if (cas_p && !cas_n) begin
        check(!ras_n, "R2 cas under ras", ras_n, 0);
        check(addr == cur_col, "R1 col addr", addr, cur_col);
        check(addr_age >= T_ASC + 1, "R4 col setup", addr_age, T_ASC + 1);
        check(cas_hi >= T_CP, "R8 cas high", cas_hi, T_CP);
        if (fall_in_row) check(since_fall >= T_PC, "R8 page cycle", since_fall, T_PC);
        fall_in_row = 1; since_fall = 1; cas_lo = 1; cas_age = 1; col_l = addr;
        if (!we_n) begin
          check(!we_p, "R5 early we", we_p, 0);
          check(oe_n && dq_oe, "R5 oe/dq", {oe_n, dq_oe}, 3);
          check(dq_out == shd({row_l, addr}), "R5 wdata", dq_out, shd({row_l, addr}));
          mem[{row_l, addr}] = dq_out;
        end else begin
          check(!oe_n, "R6 oe low", oe_n, 0);
        end
      end else begin
        since_fall++;
        if (!cas_n) begin cas_lo++; cas_age++; end
      end
      if (!cas_p && cas_n) begin
        check(cas_lo >= T_CAS, "R8 cas low", cas_lo, T_CAS);
        cas_hi = 1;
      end else if (cas_n) cas_hi++;
      if (!cas_n && !ras_p && ras_n) check(0, "R2 ras rose under cas", 1, 0);
      if (!we_n && !oe_n) check(0, "R5 oe while write", oe_n, 1);
      // data toward controller: inverted until access windows pass
      if (!cas_n && !oe_n)
        dq_drv = (cas_age >= T_CAC && ras_age >= T_RAC) ? mrd({row_l, col_l}) : ~mrd({row_l, col_l});
      else
        dq_drv = '0;
      // response
      if (rsp_valid) begin
        check(!rsp_p, "R6 single pulse", rsp_p, 0);
        if (exp_q.size() == 0) check(0, "R6 unexpected rsp", rsp_rdata, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(rsp_rdata == e, "R6 read data", rsp_rdata, e);
        end
      end
      ras_p = ras_n; cas_p = cas_n; we_p = we_n; rsp_p = rsp_valid; addr_p = addr;
    end
  end

  task automatic issue(input logic we, input logic [2*AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (we) shadow[a] = d; else exp_q.push_back(shd(a));
    cur_row = a[2*AW-1:AW]; cur_col = a[AW-1:0];
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk); #1;
    check(!req_ready, "R11 busy after accept", req_ready, 0);
  endtask

  task automatic wait_rsp();
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int f0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n, "R10 strobes", {ras_n, cas_n, we_n, oe_n}, 15);
    check(!dq_oe && !rsp_valid, "R10 dq_oe/rsp", {dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    #1;
    check(req_ready, "R10 ready", req_ready, 1);

    // R2: write opens row, read of same row is a hit
    f0 = ras_falls;
    issue(1'b1, {10'h123, 10'h045}, 4'h5);
    issue(1'b0, {10'h123, 10'h045}, 4'h0);
    wait_rsp();
    check(ras_falls - f0 == 1, "R2 hit keeps row", ras_falls - f0, 1);

    // R3: row changes force close and precharge
    issue(1'b1, {10'h123, 10'h046}, 4'hA);
    f0 = ras_falls;
    issue(1'b0, {10'h2F0, 10'h001}, 4'h0);
    wait_rsp();
    issue(1'b0, {10'h123, 10'h046}, 4'h0);
    wait_rsp();
    check(ras_falls - f0 == 2, "R3 reopen per miss", ras_falls - f0, 2);

    // R7: long same-row burst must be split by the strobe budget
    f0 = ras_falls;
    for (int i = 0; i < 8; i++) issue(1'b1, {10'h155, 10'(i * 37)}, 4'(i + 3));
    for (int i = 0; i < 8; i++) issue(1'b0, {10'h155, 10'(i * 37)}, 4'h0);
    wait_rsp();
    check(ras_falls - f0 >= 2, "R7 budget reopen", ras_falls - f0, 2);

    // R1: address corners
    issue(1'b1, 20'hFFFFF, 4'hC);
    issue(1'b1, 20'h00000, 4'h3);
    issue(1'b0, 20'hFFFFF, 4'h0);
    wait_rsp();
    issue(1'b0, 20'h00000, 4'h0);
    wait_rsp();

    // R9: refresh closes an open row and blocks requests
    issue(1'b0, {10'h0AA, 10'h3FF}, 4'h0);
    wait_rsp();
    check(!ras_n, "R9 row open before refresh", ras_n, 0);
    refresh = 1'b1;
    begin
      int n = 0;
      while (!ras_n && n < 10) begin @(negedge clk); n++; end
      check(ras_n, "R9 row closed", ras_n, 1);
    end
    repeat (T_RP + 3) @(negedge clk);
    #1;
    check(!req_ready && ras_n, "R9 ready low", req_ready, 0);
    refresh = 1'b0;
    #1;
    check(req_ready, "R11 ready after refresh", req_ready, 1);
    issue(1'b0, {10'h0AA, 10'h3FF}, 4'h0);
    wait_rsp();

    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
    finish_run();
  end

endmodule